// File: doc/BRIEF.md
# Crypto Engine Interrupt Status Combiner

This block gathers the interrupt sources of a crypto accelerator into one interrupt line and one 32-bit status view. There are two groups of sources. The first group is four level-type engine events. Each one follows a live datapath condition such as input-ready or output-ready, and each is gated by an enable bit. The second group is four DMA-done events. Each is latched from a one-cycle pulse and held until software clears it. A per-source block bit, where a one suppresses the source, gates each DMA-done event.

Software reaches every register through a simple 32-bit write port and an asynchronous read port. The combined raw and masked views place the engine events in the low half-word and the DMA-done events at bits 16 to 19. The interrupt output is the OR of the masked view, delayed by one register stage. Set and clear aliases let software enable or disable a single source without a read-modify-write.

Top module: `crypto_irq_combiner`

## Requirements
- R1: After reset, all engine enables read 0, all four DMA block bits read 1, all DMA-done latches read 0, and `irq_o` is 0. An asynchronous assertion of `rst_n` forces this state at once.
- R2: The combined raw view (word offset 0x00) equals the engine event levels in bits [3:0], ORed with the DMA-done latches in bits [19:16]. Bit 16 is context-in, 17 is context-out, 18 is data-in and 19 is data-out.
- R3: The combined masked view (0x04) equals the engine events ANDed with the engine enables, ORed with the unblocked DMA-done latches shifted to bits [19:16].
- R4: A pulse on `dma_done_i[k]` sets latch k on that clock edge. Latch k then holds (DMA raw view 0x14) until a write of one to bit k of the clear register (0x28).
- R5: When a pulse and a clear hit the same latch in the same cycle, the latch ends up set.
- R6: In the DMA block register (0x1C, read/write), a set bit removes that source from the masked views (0x04, and 0x18 for the DMA-only view). Writing ones to 0x20 clears block bits, which enables those sources. Writing ones to 0x24 sets block bits. Bits written as zero keep their value.
- R7: The engine enable register (0x08) is read/write. Writing ones to 0x0C sets enable bits and writing ones to 0x10 clears them. Other enable bits keep their value.
- R8: Engine events cannot be cleared. A write to the clear register or to a read-only view leaves the raw view unchanged. The clear register reads as 0.
- R9: `irq_o` equals the OR of all bits of the masked view one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| eng_evt_i | input | 4 | Engine event levels: context-in, context-out, data-in, data-out |
| dma_done_i | input | 4 | One-cycle DMA-done pulses, same channel order |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Byte address of the register to write or read |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
Several properties are checked on every cycle inside the RTL. A DMA-done latch never drops without a clear. A pulse always leaves its latch set. The masked view never shows a bit that is absent from the raw view, and never shows an engine bit whose enable is off. The interrupt line tracks the masked view with exactly one cycle of delay. Only the bench scenarios can show that the address decode is correct, that the set and clear aliases spare untouched bits, that the reset values are right and that writes to read-only locations are ignored. They also show that a clear cannot remove an engine event, since each of these depends on particular register writes and readback values.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Word indices of the register map (byte address >> 2)
  localparam int unsigned WIDX_W      = 4;
  localparam logic [3:0] W_RAW_ALL    = 4'd0;
  localparam logic [3:0] W_MSK_ALL    = 4'd1;
  localparam logic [3:0] W_ENG_EN     = 4'd2;
  localparam logic [3:0] W_ENG_SET    = 4'd3;
  localparam logic [3:0] W_ENG_CLR    = 4'd4;
  localparam logic [3:0] W_DMA_RAW    = 4'd5;
  localparam logic [3:0] W_DMA_MSK    = 4'd6;
  localparam logic [3:0] W_DMA_BLK    = 4'd7;
  localparam logic [3:0] W_DMA_UNBLK  = 4'd8;
  localparam logic [3:0] W_DMA_REBLK  = 4'd9;
  localparam logic [3:0] W_DMA_ACK    = 4'd10;

  typedef struct packed {
    logic eng_wr;
    logic eng_set;
    logic eng_clr;
    logic blk_wr;
    logic blk_clr;
    logic blk_set;
    logic ack;
  } wr_strb_t;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irqc_eng_gate.sv
module irqc_eng_gate #(
  parameter int unsigned N_ENG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [N_ENG-1:0] wdata_i,
  input  logic [N_ENG-1:0] evt_i,
  output logic [N_ENG-1:0] en_o,
  output logic [N_ENG-1:0] masked_o
);
  logic [N_ENG-1:0] en_q, en_d;
  logic             en_we;

  always_comb begin
    en_we = wr_i | set_i | clr_i;
    en_d  = en_q;
    if (wr_i)  en_d = wdata_i;
    if (set_i) en_d = en_q | wdata_i;
    if (clr_i) en_d = en_q & ~wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  assign en_o     = en_q;
  assign masked_o = evt_i & en_q;

  // R7: a set-alias write never drops an enable bit that was on
  a_r7_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ((en_q & $past(en_q)) == $past(en_q)));
endmodule

// File: rtl/irqc_dma_sticky.sv
module irqc_dma_sticky #(
  parameter int unsigned N_DMA = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DMA-1:0] pulse_i,
  input  logic             ack_i,
  input  logic             blk_wr_i,
  input  logic             blk_clr_i,
  input  logic             blk_set_i,
  input  logic [N_DMA-1:0] wdata_i,
  output logic [N_DMA-1:0] raw_o,
  output logic [N_DMA-1:0] blk_o,
  output logic [N_DMA-1:0] masked_o
);
  logic [N_DMA-1:0] raw_q;
  logic [N_DMA-1:0] ack_vec;
  logic [N_DMA-1:0] blk_q, blk_d;
  logic             blk_we;

  assign ack_vec = ack_i ? wdata_i : '0;

  for (genvar k = 0; k < N_DMA; k++) begin : g_latch
    logic bit_d, bit_we;
    always_comb begin
      bit_we = pulse_i[k] | ack_vec[k];
      bit_d  = pulse_i[k];  // set has priority over clear
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      raw_q[k] <= 1'b0;
      else if (bit_we) raw_q[k] <= bit_d;
    end
  end

  always_comb begin
    blk_we = blk_wr_i | blk_clr_i | blk_set_i;
    blk_d  = blk_q;
    if (blk_wr_i)  blk_d = wdata_i;
    if (blk_clr_i) blk_d = blk_q & ~wdata_i;
    if (blk_set_i) blk_d = blk_q | wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_q <= '1;
    else if (blk_we) blk_q <= blk_d;
  end

  assign raw_o    = raw_q;
  assign blk_o    = blk_q;
  assign masked_o = raw_q & ~blk_q;

  // R4: a latched bit drops only when a clear was written to it
  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((($past(raw_q) & ~$past(ack_vec)) & ~raw_q)) == '0));
  // R5: every pulse leaves its latch set, whatever the clear did
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_i) |=> ((raw_q & $past(pulse_i)) == $past(pulse_i)));
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 6,
  parameter int unsigned N_ENG = 4,
  parameter int unsigned N_DMA = 4
) (
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    raw_all_i,
  input  logic [DW-1:0]    msk_all_i,
  input  logic [N_ENG-1:0] eng_en_i,
  input  logic [N_DMA-1:0] dma_raw_i,
  input  logic [N_DMA-1:0] dma_msk_i,
  input  logic [N_DMA-1:0] dma_blk_i,
  output wr_strb_t         strb_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int unsigned IDX_LSB = 2;
  logic [WIDX_W-1:0] idx;
  logic              in_range;

  assign idx      = addr_i[IDX_LSB +: WIDX_W];
  assign in_range = (AW <= IDX_LSB + WIDX_W) ? 1'b1
                  : (addr_i >> (IDX_LSB + WIDX_W)) == '0;

  always_comb begin
    strb_o = '0;
    if (wr_i && in_range) begin
      unique case (idx)
        W_ENG_EN:    strb_o.eng_wr  = 1'b1;
        W_ENG_SET:   strb_o.eng_set = 1'b1;
        W_ENG_CLR:   strb_o.eng_clr = 1'b1;
        W_DMA_BLK:   strb_o.blk_wr  = 1'b1;
        W_DMA_UNBLK: strb_o.blk_clr = 1'b1;
        W_DMA_REBLK: strb_o.blk_set = 1'b1;
        W_DMA_ACK:   strb_o.ack     = 1'b1;
        default:     strb_o = '0;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_range) begin
      case (idx)
        W_RAW_ALL: rdata_o = raw_all_i;
        W_MSK_ALL: rdata_o = msk_all_i;
        W_ENG_EN:  rdata_o = DW'(eng_en_i);
        W_DMA_RAW: rdata_o = DW'(dma_raw_i);
        W_DMA_MSK: rdata_o = DW'(dma_msk_i);
        W_DMA_BLK: rdata_o = DW'(dma_blk_i);
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/crypto_irq_combiner.sv
module crypto_irq_combiner
  import irqc_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 6,
  parameter int unsigned N_ENG   = 4,
  parameter int unsigned N_DMA   = 4,
  parameter int unsigned DMA_LSB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENG-1:0] eng_evt_i,
  input  logic [N_DMA-1:0] dma_done_i,
  input  logic             reg_wr_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o
);
  localparam logic [DW-1:0] ENG_FIELD = DW'((64'd1 << N_ENG) - 64'd1);

  logic             rs_n;
  wr_strb_t         strb;
  logic [N_ENG-1:0] eng_en, eng_msk;
  logic [N_DMA-1:0] dma_raw, dma_blk, dma_msk;
  logic [DW-1:0]    raw_all, msk_all;
  logic             irq_d, irq_q;

  irqc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rs_n)
  );

  irqc_eng_gate #(.N_ENG(N_ENG)) u_eng (
    .clk(clk), .rst_n(rs_n),
    .wr_i(strb.eng_wr), .set_i(strb.eng_set), .clr_i(strb.eng_clr),
    .wdata_i(reg_wdata_i[N_ENG-1:0]), .evt_i(eng_evt_i),
    .en_o(eng_en), .masked_o(eng_msk)
  );

  irqc_dma_sticky #(.N_DMA(N_DMA)) u_dma (
    .clk(clk), .rst_n(rs_n), .pulse_i(dma_done_i), .ack_i(strb.ack),
    .blk_wr_i(strb.blk_wr), .blk_clr_i(strb.blk_clr), .blk_set_i(strb.blk_set),
    .wdata_i(reg_wdata_i[N_DMA-1:0]),
    .raw_o(dma_raw), .blk_o(dma_blk), .masked_o(dma_msk)
  );

  always_comb begin
    raw_all = DW'(eng_evt_i) | (DW'(dma_raw) << DMA_LSB);
    msk_all = DW'(eng_msk)   | (DW'(dma_msk) << DMA_LSB);
    irq_d   = |msk_all;
  end

  irqc_regif #(.DW(DW), .AW(AW), .N_ENG(N_ENG), .N_DMA(N_DMA)) u_regs (
    .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .raw_all_i(raw_all), .msk_all_i(msk_all), .eng_en_i(eng_en),
    .dma_raw_i(dma_raw), .dma_msk_i(dma_msk), .dma_blk_i(dma_blk),
    .strb_o(strb), .rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) irq_q <= 1'b0;
    else       irq_q <= irq_d;
  end
  assign irq_o = irq_q;

  // R3: masked view is always a subset of the raw view
  a_r3_masked_subset: assert property (@(posedge clk) disable iff (!rs_n)
    (msk_all & ~raw_all) == '0);
  // R3: no engine bit shows as masked while its enable is off
  a_r3_eng_gated: assert property (@(posedge clk) disable iff (!rs_n)
    (msk_all & ENG_FIELD & ~DW'(eng_en)) == '0);
  // R9: interrupt follows the masked view one cycle later
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rs_n)
    (|msk_all) |=> irq_o);
  a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rs_n)
    !(|msk_all) |=> !irq_o);
endmodule

// File: tb/tb_crypto_irq_combiner.sv
module tb_crypto_irq_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  eng_evt, dma_done;
  logic        reg_wr;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;
  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crypto_irq_combiner dut (
    .clk(clk), .rst_n(rst_n), .eng_evt_i(eng_evt), .dma_done_i(dma_done),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  // {req, eng, dma pulse, wr, waddr, wdata, raddr, expected read}
  localparam logic [88:0] TBL [NV] = '{
    {4'd1, 4'h0, 4'h0, 1'b0, 6'h00, 32'h0,        6'h00, 32'h0},          // R1 raw zero
    {4'd1, 4'h0, 4'h0, 1'b0, 6'h00, 32'h0,        6'h1C, 32'hF},          // R1 all blocked
    {4'd2, 4'h5, 4'h0, 1'b0, 6'h00, 32'h0,        6'h00, 32'h5},          // R2 engine levels
    {4'd3, 4'h5, 4'h0, 1'b0, 6'h00, 32'h0,        6'h04, 32'h0},          // R3 enables off
    {4'd3, 4'h5, 4'h0, 1'b1, 6'h08, 32'h1,        6'h04, 32'h1},          // R3 enable bit0
    {4'd2, 4'h5, 4'h2, 1'b0, 6'h00, 32'h0,        6'h00, 32'h0002_0005},  // R2 dma at bit17
    {4'd4, 4'h0, 4'h0, 1'b0, 6'h00, 32'h0,        6'h14, 32'h2},          // R4 held
    {4'd6, 4'h0, 4'h0, 1'b0, 6'h00, 32'h0,        6'h04, 32'h0},          // R6 blocked
    {4'd6, 4'h0, 4'h0, 1'b1, 6'h20, 32'h2,        6'h1C, 32'hD},          // R6 unblock one
    {4'd6, 4'h0, 4'h0, 1'b0, 6'h00, 32'h0,        6'h04, 32'h0002_0000},  // R6 now visible
    {4'd7, 4'h0, 4'h0, 1'b1, 6'h0C, 32'h4,        6'h08, 32'h5},          // R7 set alias
    {4'd7, 4'h0, 4'h0, 1'b1, 6'h10, 32'h1,        6'h08, 32'h4},          // R7 clear alias
    {4'd6, 4'h0, 4'h0, 1'b1, 6'h24, 32'h2,        6'h1C, 32'hF},          // R6 reblock
    {4'd3, 4'h4, 4'h0, 1'b0, 6'h00, 32'h0,        6'h04, 32'h4},          // R3 mixed gating
    {4'd4, 4'h0, 4'h0, 1'b1, 6'h28, 32'h2,        6'h14, 32'h0},          // R4 cleared
    {4'd8, 4'h4, 4'h0, 1'b1, 6'h28, 32'h0000_FFFF, 6'h00, 32'h4},         // R8 engine kept
    {4'd8, 4'h0, 4'h0, 1'b1, 6'h00, 32'hFFFF_FFFF, 6'h00, 32'h0},         // R8 RO write
    {4'd5, 4'h0, 4'h1, 1'b1, 6'h28, 32'h1,        6'h14, 32'h1},          // R5 set wins
    {4'd6, 4'h0, 4'h0, 1'b1, 6'h1C, 32'hE,        6'h18, 32'h1},          // R6 direct write
    {4'd8, 4'h0, 4'h0, 1'b0, 6'h00, 32'h0,        6'h28, 32'h0}           // R8 clear reads 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, input string req, input logic [31:0] exp);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic wr_cycle(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; eng_evt = '0; dma_done = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(6'h08, "R1 enables", 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      eng_evt   = TBL[i][84:81];
      dma_done  = TBL[i][80:77];
      reg_wr    = TBL[i][76];
      reg_addr  = TBL[i][75:70];
      reg_wdata = TBL[i][69:38];
      @(posedge clk);
      @(negedge clk);
      dma_done = '0; reg_wr = 1'b0;
      rd(TBL[i][37:32], $sformatf("R%0d v%0d", TBL[i][88:85], i), TBL[i][31:0]);
    end

    // R9: DMA latch 0 unblocked, so the line is high
    chk("R9 irq high", {31'd0, irq}, 32'd1);
    rd(6'h04, "R3 masked dma0", 32'h0001_0000);
    wr_cycle(6'h28, 32'h1);
    chk("R9 latency", {31'd0, irq}, 32'd1);
    rd(6'h04, "R4 ack masked", 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R9 irq low", {31'd0, irq}, 32'd0);
    eng_evt = 4'h4;
    @(posedge clk); @(negedge clk);
    chk("R9 engine irq", {31'd0, irq}, 32'd1);

    // R1: asynchronous reset in mid-run
    rst_n = 1'b0;
    #1 chk("R1 async irq", {31'd0, irq}, 32'd0);
    rd(6'h08, "R1 async en", 32'h0);
    rd(6'h1C, "R1 async blk", 32'hF);
    rd(6'h04, "R1 async msk", 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd(6'h00, "R2 after reset", 32'h4);
    chk("R1 irq after", {31'd0, irq}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule